// File: doc/BRIEF.md
# Returned-Data Loopback Error Checker

The block checks that every character the local UART transmitter sends comes back unchanged from a remote station that echoes it, with a half-bit-time delay. Each transmitted character is stored in a small in-order queue. Each returned character, delivered by the framing logic together with its parity and framing flags, is compared against the oldest stored character, and that character is then removed. A data mismatch, a parity error, a framing error, or a returned character that finds no stored character sets a sticky error bit. The error bit drives the interrupt request.

A two-bit mode field turns the check on and selects the transmit clock edge on which the returned serial stream is sampled. The edge choice is passed to the framing logic outside this block on two outputs. The mode field and the error bit share one 8-bit control/status register. The error bit is cleared by writing a 1 to its bit position.

Top module: `echo_verify`

## Requirements
- R1: After reset, the register reads 0x00, `irq_o` is low, and both `sample_en_o` and `sample_inv_o` are low.
- R2: The register holds the mode in bits [2:1] and the error flag in bit 3. Bits 7:4 and bit 0 read as 0. A write loads bits [2:1] into the mode. Software cannot set the error bit by writing to it.
- R3: When returned characters match the stored characters in transmit order, no error is raised. This holds with up to DEPTH (default 4) characters outstanding, and with transmit and return strobes interleaved.
- R4: While checking is on, a returned character whose data differs from the oldest stored character sets the error bit and `irq_o` at the next clock edge.
- R5: A returned character with its parity-error flag set raises the error, even when the data matches.
- R6: A returned character with its framing-error flag set raises the error, even when the data matches.
- R7: A returned character that arrives while the queue is empty raises the error. A transmit strobe in the same cycle is not visible to that comparison.
- R8: A register write with bit 3 = 1 clears the error bit and `irq_o`. A write with bit 3 = 0 leaves the error bit unchanged.
- R9: When an error event and a clearing write fall in the same cycle, the error bit stays set.
- R10: Mode 00 (off) and mode 11 (reserved) disable checking. In these modes, strobes are ignored and raise no error. While checking is disabled the queue is flushed, so characters sent before disabling are not compared after checking is turned back on.
- R11: `sample_en_o` is high in modes 01 and 10. `sample_inv_o` is high only in mode 10, which selects sampling on the inverted transmit clock. Mode 01 selects the rising edge of the transmit clock.
- R12: A transmit strobe while DEPTH characters are already stored is dropped. The later echo of the dropped character finds the queue empty and raises the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_valid_i | input | 1 | A character was transmitted this cycle |
| tx_data_i | input | DW | Transmitted character |
| rx_valid_i | input | 1 | A returned character is presented this cycle |
| rx_data_i | input | DW | Returned character |
| rx_par_err_i | input | 1 | Returned character had a parity error |
| rx_frm_err_i | input | 1 | Returned character had a framing error |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| sample_en_o | output | 1 | Return sampling enabled |
| sample_inv_o | output | 1 | Sample on inverted transmit clock |
| irq_o | output | 1 | Interrupt request (error bit) |

## Verification
The comparison is tested with several kinds of returned stream:
- In-order echoes, both in bursts filling the queue and interleaved with transmits. These show that ordering and occupancy are tracked correctly.
- Single-bit data corruption, and matching data with only the parity or framing flag set. These separate the three error causes.
- Returns against an empty queue, one extra transmit beyond the queue depth, and a transmit sent before a disable/enable cycle. These separate overflow drop, flush and empty handling.
- A clearing write that coincides with a new error. This distinguishes set priority from clear priority.

// File: rtl/echo_pkg.sv
package echo_pkg;
  typedef enum logic [1:0] {
    CHK_OFF  = 2'b00,
    CHK_RISE = 2'b01,
    CHK_FALL = 2'b10,
    CHK_RSVD = 2'b11
  } chk_mode_e;

  localparam int unsigned ERR_BIT  = 3;
  localparam int unsigned MODE_LSB = 1;
endpackage

// File: rtl/echo_fifo.sv
module echo_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[g] <= '0;
      else if (push_ok && !flush_i && wr_ptr_q == AW'(g)) mem_q[g] <= push_data_i;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R12
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o); // R12
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R10
endmodule

// File: rtl/echo_status.sv
module echo_status
  import echo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       err_evt_i,
  output chk_mode_e  mode_o,
  output logic       err_o
);
  logic clr;

  assign clr = we_i && wdata_i[ERR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= CHK_OFF;
      err_o  <= 1'b0;
    end else begin
      if (we_i) mode_o <= chk_mode_e'(wdata_i[MODE_LSB +: 2]);
      // set wins over clear
      err_o <= err_evt_i || (err_o && !clr);
    end
  end

  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |=> err_o); // R4
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !err_evt_i) |=> !err_o); // R8
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr) |=> err_o); // R8
endmodule

// File: rtl/echo_verify.sv
module echo_verify
  import echo_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_valid_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_par_err_i,
  input  logic          rx_frm_err_i,
  input  logic          reg_we_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  output logic          sample_en_o,
  output logic          sample_inv_o,
  output logic          irq_o
);
  chk_mode_e     mode;
  logic          err;
  logic          active;
  logic [DW-1:0] head;
  logic          empty, full;
  logic          rx_chk, err_evt;

  assign active = (mode == CHK_RISE) || (mode == CHK_FALL);
  assign rx_chk = active && rx_valid_i;
  assign err_evt = rx_chk &&
                   (empty || (head != rx_data_i) || rx_par_err_i || rx_frm_err_i);

  echo_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (!active),
    .push_i      (active && tx_valid_i),
    .push_data_i (tx_data_i),
    .pop_i       (rx_chk),
    .head_o      (head),
    .empty_o     (empty),
    .full_o      (full)
  );

  echo_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .err_evt_i (err_evt),
    .mode_o    (mode),
    .err_o     (err)
  );

  always_comb begin
    reg_rdata_o                   = '0;
    reg_rdata_o[ERR_BIT]          = err;
    reg_rdata_o[MODE_LSB +: 2]    = mode;
  end

  assign sample_en_o  = active;
  assign sample_inv_o = (mode == CHK_FALL);
  assign irq_o        = err;

  AST_EDGE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_inv_o |-> sample_en_o); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_en_o && !irq_o && !(reg_we_i && reg_wdata_i[MODE_LSB +: 2] != 2'b00
      && reg_wdata_i[MODE_LSB +: 2] != 2'b11)) |=> !irq_o); // R10
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_en_o && rx_valid_i && (rx_par_err_i || rx_frm_err_i)) |=> irq_o); // R5
endmodule

// File: tb/echo_verify_tb_top.sv
module echo_verify_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0, rx_valid = 1'b0, pe = 1'b0, fe = 1'b0, we = 1'b0;
  logic [7:0] tx_data = '0, rx_data = '0, wdata = '0, rdata;
  logic       s_en, s_inv, irq;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  echo_verify #(.DW(8), .DEPTH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_par_err_i(pe), .rx_frm_err_i(fe),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sample_en_o(s_en), .sample_inv_o(s_inv), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs valid at the following negedge
  task automatic cyc(input logic t, input logic [7:0] td, input logic r, input logic [7:0] rd,
                     input logic p, input logic f, input logic w, input logic [7:0] wd);
    tx_valid = t; tx_data = td; rx_valid = r; rx_data = rd; pe = p; fe = f;
    we = w; wdata = wd;
    @(negedge clk);
    tx_valid = 0; rx_valid = 0; pe = 0; fe = 0; we = 0;
  endtask

  task automatic wr(input logic [7:0] d); cyc(0, 0, 0, 0, 0, 0, 1, d); endtask
  task automatic tx(input logic [7:0] d); cyc(1, d, 0, 0, 0, 0, 0, 0); endtask
  task automatic rx(input logic [7:0] d, input logic p, input logic f); cyc(0, 0, 1, d, p, f, 0, 0); endtask
  task automatic restart(); wr(8'h08); wr(8'h02); endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 sample", {6'b0, s_en, s_inv}, 8'h00);
  endtask

  task automatic t_regs();
    wr(8'h02); chk("R2 mode01", rdata, 8'h02); chk("R11 rise", {6'b0, s_en, s_inv}, 8'h02);
    wr(8'h04); chk("R2 mode10", rdata, 8'h04); chk("R11 fall", {6'b0, s_en, s_inv}, 8'h03);
    wr(8'h06); chk("R2 mode11", rdata, 8'h06); chk("R11 rsvd", {6'b0, s_en, s_inv}, 8'h00);
    wr(8'hF1); chk("R2 ro bits", rdata, 8'h00);
  endtask

  task automatic t_match();
    restart();
    tx(8'h11); tx(8'h22); tx(8'h33); tx(8'h44);
    rx(8'h11, 0, 0); rx(8'h22, 0, 0); rx(8'h33, 0, 0); rx(8'h44, 0, 0);
    chk("R3 burst", {7'b0, irq}, 8'h00);
    tx(8'h55); tx(8'h66); rx(8'h55, 0, 0); tx(8'h77); rx(8'h66, 0, 0); rx(8'h77, 0, 0);
    chk("R3 interleave", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_mismatch();
    restart();
    tx(8'h5A); rx(8'h5B, 0, 0);
    chk("R4 irq", {7'b0, irq}, 8'h01); chk("R4 rdata", rdata, 8'h0A);
    wr(8'h02); chk("R8 no clear", {7'b0, irq}, 8'h01);
    wr(8'h0A); chk("R8 clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_flags();
    restart(); tx(8'h3C); rx(8'h3C, 1, 0); chk("R5 parity", {7'b0, irq}, 8'h01);
    restart(); tx(8'hC3); rx(8'hC3, 0, 1); chk("R6 framing", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_empty();
    restart(); rx(8'h00, 0, 0); chk("R7 empty", {7'b0, irq}, 8'h01);
    restart(); cyc(1, 8'h9E, 1, 8'h9E, 0, 0, 0, 0); chk("R7 same cycle", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_race();
    restart(); tx(8'h01); rx(8'h02, 0, 0);
    tx(8'h10); cyc(0, 0, 1, 8'h20, 0, 0, 1, 8'h0A);
    chk("R9 set wins", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_disabled();
    restart(); wr(8'h00);
    tx(8'h12); rx(8'h34, 1, 1); chk("R10 off", {7'b0, irq}, 8'h00);
    wr(8'h06); tx(8'h12); rx(8'h34, 1, 1); chk("R10 reserved", {7'b0, irq}, 8'h00);
    wr(8'h02); tx(8'h12); wr(8'h00); wr(8'h02); rx(8'h12, 0, 0);
    chk("R10 flush", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_full();
    restart();
    tx(8'hA1); tx(8'hA2); tx(8'hA3); tx(8'hA4); tx(8'hA5);
    rx(8'hA1, 0, 0); rx(8'hA2, 0, 0); rx(8'hA3, 0, 0); rx(8'hA4, 0, 0);
    chk("R12 stored", {7'b0, irq}, 8'h00);
    rx(8'hA5, 0, 0); chk("R12 dropped", {7'b0, irq}, 8'h01);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs(); t_match(); t_mismatch(); t_flags();
        t_empty(); t_race(); t_disabled(); t_full();
      end
      begin
        repeat (5000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule